// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block is a hardware state machine that takes a USB subsystem from its fully reset, powered-down condition to a running controller. A single start pulse launches the sequence. The block then drives the subsystem clock and reset-release lines, the PHY power-down control, the reference clock source select, the PHY resets, the parallel control-register interface select and its clock gate, the SRAM load-complete flag and the active-low controller reset. It applies each change in a fixed order. Every gap between steps is counted in clock cycles, and the cycle counts come from a clock-frequency parameter given in kHz.

Before it lets the controller out of reset, the sequencer waits for the PHY to report that its SRAM is initialised. It samples a synchronised copy of that status at a fixed interval and gives up after a bounded number of samples. Three flags report the result: busy while a sequence runs, done after a clean finish, and timeout when the PHY never reports ready. Software or a system controller only has to pulse start and watch these flags.

Top module: `usb_phy_pwrup_seq`

## Requirements
- R1: A synchronous reset drives every output to its safe level on the next edge. Safe levels are: clock enables and reset releases all 0, power-down 1, pad reference select 0, controller reset (active low) 0, PHY power-on reset 1, PHY reset 1, interface select 0, interface clock enable 0, load-complete 0, busy 0, done 0, timeout 0.
- R2: While busy is low, a start pulse sampled on an edge sets busy on that edge and returns every other output to its R1 level. While busy is high, a start pulse changes nothing.
- R3: One cycle after start is accepted, all seven clock-enable bits and all seven reset-release bits go to 1 together, and power-down goes to 0 on the same edge. The bits are, from 0 to 6: system, reference, alternate reference, suspend, core, low-jitter, PHY test.
- R4: CYC(30 us) cycles after the R3 edge, pad reference select goes to 1 and the controller reset is held at 0.
- R5: CYC(20 us) cycles after the R4 edge, the PHY power-on reset and the PHY reset both go to 0 on the same edge.
- R6: One cycle after the R5 edge, the interface clock enable is 0. CYC(2 us) cycles later, interface select goes to 1. One cycle after that, the interface clock enable goes to 1. Select never rises while the enable is 1.
- R7: The SRAM-ready input passes through two flops. It is sampled only on poll edges, which fall every CYC(1 ms) cycles after the R6 clock-enable edge. A level that reaches the input pin at edge P-2 is seen at poll edge P. A level that first appears at P-1, or that is high only between poll edges, is not seen at P.
- R8: On the poll edge that sees ready, load-complete goes to 1. CYC(20 us) cycles later, the controller reset goes to 1, done goes to 1 and busy goes to 0.
- R9: If ready is not seen by the tenth poll edge, that edge sets timeout to 1 and busy to 0. Every other output keeps its value, and the controller stays in reset.
- R10: Done and timeout are never 1 together. Each holds until the next accepted start or reset.
- R11: CYC(t) = ceil(t × CLK_KHZ / 1000 µs⁻¹ kHz), so no wait is ever shorter than its minimum. At 1333 kHz the values are: 30 us → 40, 20 us → 27, 2 us → 3, 1 ms → 1333.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse |
| sramInitDone | input | 1 | PHY SRAM initialised status, asynchronous |
| subClkEn | output | 7 | Subsystem clock enables |
| subRstRel | output | 7 | Subsystem reset releases |
| phyIddq | output | 1 | PHY power-down, 1 = powered down |
| refPadSel | output | 1 | 1 = PHY reference clock taken from pad |
| phyPor | output | 1 | PHY power-on reset, 1 = asserted |
| phyRst | output | 1 | PHY reset, 1 = asserted |
| crIfSel | output | 1 | Parallel control interface select |
| crIfClkEn | output | 1 | Parallel control interface clock enable |
| sramLoadDone | output | 1 | SRAM external load complete |
| ctrlRstN | output | 1 | Controller reset, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished cleanly (sticky) |
| timeout | output | 1 | SRAM ready never seen (sticky) |

## Verification
The bench runs the sequence with four patterns on the SRAM-ready input. In the first, ready arrives in the middle of the third poll interval, which shows that the block acts only on poll edges and then releases the controller. In the second, ready never arrives, which separates the timeout path from a clean finish. In the last two, ready arrives either one cycle too late or just in time for the first poll, which pins down the two-flop latency. Start pulses during busy, a reset in mid-sequence, and a slow clock whose waits need rounding up make sure that ignored inputs, safe levels and cycle counts are compared against the model on every edge.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  // Which wait the shared timer is loaded for
  typedef enum logic [2:0] {
    TMR_PWR  = 3'd0,
    TMR_HOLD = 3'd1,
    TMR_GATE = 3'd2,
    TMR_POLL = 3'd3,
    TMR_REL  = 3'd4
  } tmrSel_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    goSafe;
    logic    clkOn;
    logic    refSel;
    logic    phyOn;
    logic    crOff;
    logic    crSel;
    logic    crOn;
    logic    ldDone;
    logic    coreOn;
    logic    setTimeout;
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    pollClr;
    logic    pollInc;
  } seqStrobe_t;

  // Microseconds to clock cycles, rounded up
  function automatic int unsigned usToCycles(input int unsigned us, input int unsigned khz);
    longint unsigned prod;
    prod = longint'(us) * longint'(khz) + 64'd999;
    return 32'(prod / 64'd1000);
  endfunction

endpackage

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       tmrZero,
  input  logic       pollLast,
  input  logic       sramSeen,
  output seqStrobe_t stb
);

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_CLK_ON = 4'd1,
    ST_W_PWR  = 4'd2,
    ST_W_HOLD = 4'd3,
    ST_CR_OFF = 4'd4,
    ST_W_GATE = 4'd5,
    ST_CR_ON  = 4'd6,
    ST_POLL   = 4'd7,
    ST_W_REL  = 4'd8
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.goSafe = 1'b1;
          stateNext  = ST_CLK_ON;
        end
      end
      ST_CLK_ON: begin
        stb.clkOn   = 1'b1;
        stb.tmrLoad = 1'b1;
        stb.tmrSel  = TMR_PWR;
        stateNext   = ST_W_PWR;
      end
      ST_W_PWR: begin
        if (tmrZero) begin
          stb.refSel  = 1'b1;
          stb.tmrLoad = 1'b1;
          stb.tmrSel  = TMR_HOLD;
          stateNext   = ST_W_HOLD;
        end
      end
      ST_W_HOLD: begin
        if (tmrZero) begin
          stb.phyOn = 1'b1;
          stateNext = ST_CR_OFF;
        end
      end
      ST_CR_OFF: begin
        stb.crOff   = 1'b1;
        stb.tmrLoad = 1'b1;
        stb.tmrSel  = TMR_GATE;
        stateNext   = ST_W_GATE;
      end
      ST_W_GATE: begin
        if (tmrZero) begin
          stb.crSel = 1'b1;
          stateNext = ST_CR_ON;
        end
      end
      ST_CR_ON: begin
        stb.crOn    = 1'b1;
        stb.tmrLoad = 1'b1;
        stb.tmrSel  = TMR_POLL;
        stb.pollClr = 1'b1;
        stateNext   = ST_POLL;
      end
      ST_POLL: begin
        if (tmrZero) begin
          if (sramSeen) begin
            stb.ldDone  = 1'b1;
            stb.tmrLoad = 1'b1;
            stb.tmrSel  = TMR_REL;
            stateNext   = ST_W_REL;
          end else if (pollLast) begin
            stb.setTimeout = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            stb.tmrLoad = 1'b1;
            stb.tmrSel  = TMR_POLL;
            stb.pollInc = 1'b1;
          end
        end
      end
      ST_W_REL: begin
        if (tmrZero) begin
          stb.coreOn = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_CLK_ON));

  // R7
  poll_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL && !tmrZero) |=> (state == ST_POLL));

endmodule

// File: rtl/pwrup_seq_dp.sv
module pwrup_seq_dp
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 400000,
  parameter int unsigned CLK_LINES   = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POLL_COUNT  = 10,
  parameter int unsigned PWR_US      = 30,
  parameter int unsigned HOLD_US     = 20,
  parameter int unsigned GATE_US     = 2,
  parameter int unsigned POLL_US     = 1000,
  parameter int unsigned REL_US      = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqStrobe_t           stb,
  input  logic                 sramInitDone,
  output logic                 tmrZero,
  output logic                 pollLast,
  output logic                 sramSeen,
  output logic [CLK_LINES-1:0] subClkEn,
  output logic [CLK_LINES-1:0] subRstRel,
  output logic                 phyIddq,
  output logic                 refPadSel,
  output logic                 phyPor,
  output logic                 phyRst,
  output logic                 crIfSel,
  output logic                 crIfClkEn,
  output logic                 sramLoadDone,
  output logic                 ctrlRstN,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout
);

  localparam int unsigned CYC_PWR  = usToCycles(PWR_US,  CLK_KHZ);
  localparam int unsigned CYC_HOLD = usToCycles(HOLD_US, CLK_KHZ);
  localparam int unsigned CYC_GATE = usToCycles(GATE_US, CLK_KHZ);
  localparam int unsigned CYC_POLL = usToCycles(POLL_US, CLK_KHZ);
  localparam int unsigned CYC_REL  = usToCycles(REL_US,  CLK_KHZ);
  localparam int unsigned MAX_A    = (CYC_PWR  > CYC_HOLD) ? CYC_PWR  : CYC_HOLD;
  localparam int unsigned MAX_B    = (CYC_GATE > CYC_POLL) ? CYC_GATE : CYC_POLL;
  localparam int unsigned MAX_C    = (MAX_A    > MAX_B)    ? MAX_A    : MAX_B;
  localparam int unsigned CYC_MAX  = (MAX_C    > CYC_REL)  ? MAX_C    : CYC_REL;
  localparam int unsigned TMR_W    = $clog2(CYC_MAX + 1);
  localparam int unsigned PC_W     = $clog2((POLL_COUNT > 1) ? POLL_COUNT : 2);

  // Input synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], sramInitDone};
  end
  assign sramSeen = syncQ[SYNC_STAGES-1];

  // Shared wait timer, loaded with N-1 so the next step lands N cycles later
  logic [TMR_W-1:0] tmr, tmrLoadVal;
  always_comb begin
    unique case (stb.tmrSel)
      TMR_PWR:  tmrLoadVal = TMR_W'(CYC_PWR  - 1);
      TMR_HOLD: tmrLoadVal = TMR_W'(CYC_HOLD - 1);
      TMR_GATE: tmrLoadVal = TMR_W'(CYC_GATE - 1);
      TMR_POLL: tmrLoadVal = TMR_W'(CYC_POLL - 1);
      TMR_REL:  tmrLoadVal = TMR_W'(CYC_REL  - 1);
      default:  tmrLoadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              tmr <= '0;
    else if (stb.tmrLoad) tmr <= tmrLoadVal;
    else if (tmr != '0)   tmr <= tmr - 1'b1;
  end
  assign tmrZero = (tmr == '0);

  // Poll counter
  logic [PC_W-1:0] pollCnt;
  always_ff @(posedge clk) begin
    if (rst || stb.pollClr) pollCnt <= '0;
    else if (stb.pollInc)   pollCnt <= pollCnt + 1'b1;
  end
  assign pollLast = (pollCnt == PC_W'(POLL_COUNT - 1));

  // Subsystem control outputs
  always_ff @(posedge clk) begin
    if (rst || stb.goSafe) begin
      subClkEn     <= '0;
      subRstRel    <= '0;
      phyIddq      <= 1'b1;
      refPadSel    <= 1'b0;
      phyPor       <= 1'b1;
      phyRst       <= 1'b1;
      crIfSel      <= 1'b0;
      crIfClkEn    <= 1'b0;
      sramLoadDone <= 1'b0;
      ctrlRstN     <= 1'b0;
    end else begin
      if (stb.clkOn) begin
        subClkEn  <= '1;
        subRstRel <= '1;
        phyIddq   <= 1'b0;
      end
      if (stb.refSel) begin
        refPadSel <= 1'b1;
        ctrlRstN  <= 1'b0;
      end
      if (stb.phyOn) begin
        phyPor <= 1'b0;
        phyRst <= 1'b0;
      end
      if (stb.crOff)  crIfClkEn    <= 1'b0;
      if (stb.crSel)  crIfSel      <= 1'b1;
      if (stb.crOn)   crIfClkEn    <= 1'b1;
      if (stb.ldDone) sramLoadDone <= 1'b1;
      if (stb.coreOn) ctrlRstN     <= 1'b1;
    end
  end

  // Status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else if (stb.goSafe) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else if (stb.coreOn) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (stb.setTimeout) begin
      busy    <= 1'b0;
      timeout <= 1'b1;
    end
  end

  // R3
  lines_together_chk: assert property (@(posedge clk) disable iff (rst)
    (subClkEn == subRstRel) && (subClkEn == '0 || subClkEn == '1));

  // R4
  ref_after_power_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(refPadSel) |-> (!phyIddq && subClkEn == '1 && !ctrlRstN));

  // R5
  phy_resets_pair_chk: assert property (@(posedge clk) disable iff (rst)
    phyPor == phyRst);

  // R6
  sel_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crIfSel) |-> !crIfClkEn);

  // R8
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrlRstN) |-> (sramLoadDone && done && !busy));

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

endmodule

// File: rtl/usb_phy_pwrup_seq.sv
module usb_phy_pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 400000,
  parameter int unsigned CLK_LINES   = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POLL_COUNT  = 10,
  parameter int unsigned PWR_US      = 30,
  parameter int unsigned HOLD_US     = 20,
  parameter int unsigned GATE_US     = 2,
  parameter int unsigned POLL_US     = 1000,
  parameter int unsigned REL_US      = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 sramInitDone,
  output logic [CLK_LINES-1:0] subClkEn,
  output logic [CLK_LINES-1:0] subRstRel,
  output logic                 phyIddq,
  output logic                 refPadSel,
  output logic                 phyPor,
  output logic                 phyRst,
  output logic                 crIfSel,
  output logic                 crIfClkEn,
  output logic                 sramLoadDone,
  output logic                 ctrlRstN,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout
);

  seqStrobe_t stb;
  logic       tmrZero;
  logic       pollLast;
  logic       sramSeen;

  pwrup_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tmrZero  (tmrZero),
    .pollLast (pollLast),
    .sramSeen (sramSeen),
    .stb      (stb)
  );

  pwrup_seq_dp #(
    .CLK_KHZ     (CLK_KHZ),
    .CLK_LINES   (CLK_LINES),
    .SYNC_STAGES (SYNC_STAGES),
    .POLL_COUNT  (POLL_COUNT),
    .PWR_US      (PWR_US),
    .HOLD_US     (HOLD_US),
    .GATE_US     (GATE_US),
    .POLL_US     (POLL_US),
    .REL_US      (REL_US)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .sramInitDone (sramInitDone),
    .tmrZero      (tmrZero),
    .pollLast     (pollLast),
    .sramSeen     (sramSeen),
    .subClkEn     (subClkEn),
    .subRstRel    (subRstRel),
    .phyIddq      (phyIddq),
    .refPadSel    (refPadSel),
    .phyPor       (phyPor),
    .phyRst       (phyRst),
    .crIfSel      (crIfSel),
    .crIfClkEn    (crIfClkEn),
    .sramLoadDone (sramLoadDone),
    .ctrlRstN     (ctrlRstN),
    .busy         (busy),
    .done         (done),
    .timeout      (timeout)
  );

endmodule

// File: tb/usb_phy_pwrup_seq_test.sv
module usb_phy_pwrup_seq_test;

  localparam int KHZ   = 1333;
  localparam int POLLS = 10;

  function automatic int ceilCyc(input int us);
    return int'($ceil(real'(us) * real'(KHZ) / 1000.0));
  endfunction

  int n30, n20, n2, nMs;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, start = 1'b0, sramIn = 1'b0;
  logic [6:0] subClkEn, subRstRel;
  logic       phyIddq, refPadSel, phyPor, phyRst, crIfSel, crIfClkEn;
  logic       sramLoadDone, ctrlRstN, busy, done, timeout;

  usb_phy_pwrup_seq #(.CLK_KHZ(KHZ)) uut (
    .clk(clk), .rst(rst), .start(start), .sramInitDone(sramIn),
    .subClkEn(subClkEn), .subRstRel(subRstRel), .phyIddq(phyIddq),
    .refPadSel(refPadSel), .phyPor(phyPor), .phyRst(phyRst),
    .crIfSel(crIfSel), .crIfClkEn(crIfClkEn), .sramLoadDone(sramLoadDone),
    .ctrlRstN(ctrlRstN), .busy(busy), .done(done), .timeout(timeout)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // Reference model, event-scheduled by edge number
  int   cyc = 0, step = 0, whenE = 0, polls = 0, startEdge = 0;
  bit   mValid = 1'b0, mRstLast = 1'b0;
  logic s1 = 1'b0, s2 = 1'b0;
  logic [6:0] mClk, mRel;
  logic mIddq, mRef, mPor, mPrst, mSel, mCen, mLd, mCrst, mBusy, mDone, mTo;

  task automatic mSafe();
    mClk = '0; mRel = '0; mIddq = 1; mRef = 0; mPor = 1; mPrst = 1;
    mSel = 0; mCen = 0; mLd = 0; mCrst = 0;
  endtask

  always @(posedge clk) begin
    logic seen;
    seen = s2; s2 = s1; s1 = sramIn;
    cyc++;
    mRstLast = rst;
    if (rst) begin
      mValid = 1; mSafe(); mBusy = 0; mDone = 0; mTo = 0; step = 0; s1 = 0; s2 = 0;
    end else if (!mBusy && start) begin
      mSafe(); mBusy = 1; mDone = 0; mTo = 0; step = 1; whenE = cyc + 1; startEdge = cyc;
    end else if (mBusy && cyc == whenE) begin
      case (step)
        1: begin mClk = '1; mRel = '1; mIddq = 0; step = 2; whenE += n30; end
        2: begin mRef = 1; mCrst = 0; step = 3; whenE += n20; end
        3: begin mPor = 0; mPrst = 0; step = 4; whenE += 1; end
        4: begin mCen = 0; step = 5; whenE += n2; end
        5: begin mSel = 1; step = 6; whenE += 1; end
        6: begin mCen = 1; step = 7; polls = 0; whenE += nMs; end
        7: begin
          polls++;
          if (seen) begin mLd = 1; step = 8; whenE += n20; end
          else if (polls == POLLS) begin mTo = 1; mBusy = 0; step = 0; end
          else whenE += nMs;
        end
        8: begin mCrst = 1; mDone = 1; mBusy = 0; step = 0; end
        default: ;
      endcase
    end
  end

  task automatic cmp(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at edge %0d: act=%0h exp=%0h", mRstLast ? "R1" : tag, nm, cyc, act, exp);
    end
  endtask

  // Compare with the model on every clock
  always @(negedge clk) begin
    if (mValid && !finished) begin
      checks++;
      cmp("R3", "subClkEn", 32'(subClkEn), 32'(mClk));
      cmp("R3", "subRstRel", 32'(subRstRel), 32'(mRel));
      cmp("R3", "phyIddq", 32'(phyIddq), 32'(mIddq));
      cmp("R4", "refPadSel", 32'(refPadSel), 32'(mRef));
      cmp("R5", "phyPor", 32'(phyPor), 32'(mPor));
      cmp("R5", "phyRst", 32'(phyRst), 32'(mPrst));
      cmp("R6", "crIfSel", 32'(crIfSel), 32'(mSel));
      cmp("R6", "crIfClkEn", 32'(crIfClkEn), 32'(mCen));
      cmp("R7", "sramLoadDone", 32'(sramLoadDone), 32'(mLd));
      cmp("R8", "ctrlRstN", 32'(ctrlRstN), 32'(mCrst));
      cmp("R2", "busy", 32'(busy), 32'(mBusy));
      cmp("R10", "done", 32'(done), 32'(mDone));
      cmp("R9", "timeout", 32'(timeout), 32'(mTo));
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  function automatic int pollEdge(input int e0, input int k);
    return e0 + 1 + n30 + n20 + 1 + n2 + 1 + k * nMs;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      failures++;
      $display("FAIL R2 watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int e0;
    n30 = ceilCyc(30); n20 = ceilCyc(20); n2 = ceilCyc(2); nMs = ceilCyc(1000);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "reset clocks off", 32'(subClkEn), 0);
    check("R1", "reset ctrl held", 32'(ctrlRstN), 0);
    check("R1", "reset iddq", 32'(phyIddq), 1);
    check("R11", "30us rounds to 40", 32'(n30), 40);
    check("R11", "20us rounds to 27", 32'(n20), 27);

    // A: ready arrives inside the third poll interval
    pulseStart(); e0 = startEdge;
    check("R2", "busy after start", 32'(busy), 1);
    waitCyc(e0 + 1);
    check("R3", "all clock lines on", 32'(subClkEn), 32'h7f);
    check("R3", "iddq cleared", 32'(phyIddq), 0);
    waitCyc(e0 + 5); pulseStart();
    check("R2", "start while busy ignored", 32'(subClkEn), 32'h7f);
    waitCyc(e0 + n30);
    check("R11", "ref select not early", 32'(refPadSel), 0);
    waitCyc(e0 + 1 + n30);
    check("R4", "ref select at gap", 32'(refPadSel), 1);
    waitCyc(e0 + n30 + n20);
    check("R5", "phy still in reset", 32'(phyRst), 1);
    waitCyc(e0 + 1 + n30 + n20);
    check("R5", "phy por released", 32'(phyPor), 0);
    check("R5", "phy reset released", 32'(phyRst), 0);
    waitCyc(e0 + 2 + n30 + n20 + n2);
    check("R6", "select set", 32'(crIfSel), 1);
    check("R6", "gate low at select", 32'(crIfClkEn), 0);
    waitCyc(e0 + 3 + n30 + n20 + n2);
    check("R6", "gate back on", 32'(crIfClkEn), 1);
    waitCyc(pollEdge(e0, 2) + 100); sramIn = 1'b1;
    waitCyc(pollEdge(e0, 3) - 1);
    check("R7", "no action between polls", 32'(sramLoadDone), 0);
    waitCyc(pollEdge(e0, 3));
    check("R8", "load done at poll", 32'(sramLoadDone), 1);
    waitCyc(pollEdge(e0, 3) + n20);
    check("R8", "controller released", 32'(ctrlRstN), 1);
    check("R8", "done set", 32'(done), 1);
    waitCyc(cyc + 20);
    check("R10", "done sticky", 32'(done), 1);

    // B: ready never arrives
    sramIn = 1'b0;
    pulseStart(); e0 = startEdge;
    check("R10", "done cleared by start", 32'(done), 0);
    waitCyc(pollEdge(e0, POLLS) - 1);
    check("R9", "no timeout early", 32'(timeout), 0);
    waitCyc(pollEdge(e0, POLLS));
    check("R9", "timeout at tenth poll", 32'(timeout), 1);
    check("R9", "controller kept in reset", 32'(ctrlRstN), 0);
    waitCyc(cyc + 10);
    check("R10", "timeout sticky", 32'(timeout), 1);

    // C: ready one cycle too late for the first poll
    pulseStart(); e0 = startEdge;
    check("R10", "timeout cleared by start", 32'(timeout), 0);
    waitCyc(e0 + 300); sramIn = 1'b1;
    @(negedge clk); sramIn = 1'b0;
    waitCyc(pollEdge(e0, 1) - 2); sramIn = 1'b1;
    waitCyc(pollEdge(e0, 1));
    check("R7", "late level not seen", 32'(sramLoadDone), 0);
    waitCyc(pollEdge(e0, 2));
    check("R7", "seen at next poll", 32'(sramLoadDone), 1);
    waitCyc(pollEdge(e0, 2) + n20 + 2);

    // D: ready just in time for the first poll
    sramIn = 1'b0;
    pulseStart(); e0 = startEdge;
    waitCyc(pollEdge(e0, 1) - 3); sramIn = 1'b1;
    waitCyc(pollEdge(e0, 1));
    check("R7", "two-flop latency met", 32'(sramLoadDone), 1);

    // E: reset mid-sequence
    waitCyc(cyc + 10);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1", "clocks off after reset", 32'(subClkEn), 0);
    check("R1", "phy por after reset", 32'(phyPor), 1);
    check("R1", "busy low after reset", 32'(busy), 0);
    check("R1", "load done low after reset", 32'(sramLoadDone), 0);
    repeat (5) @(negedge clk);

    summary();
    $finish;
  end

endmodule